// File: doc/BRIEF.md
# Head Seek and Recalibrate Stepper

This block drives the head positioner of up to four floppy drives for the two positioning commands of a disc controller. A seek moves the head of the chosen drive from its present cylinder to a destination cylinder between 0 and 255. A recalibrate steps the head outward until the drive reports track 0. The block keeps one present-cylinder register per drive. It emits step pulses and a direction level, and it spaces the pulses by a programmed step-rate count of millisecond ticks. No data moves between host and controller while it works.

While a command runs, the busy bit of the active drive is set. When the command ends, the block latches a status byte and raises an interrupt. A later sense request returns that status byte and the drive's present cylinder, then clears the interrupt. Only one command runs at a time. A start request that arrives while a command is running is ignored.

Top module: `head_step_ctrl`

## Requirements
- R1: After reset, step, busy, irq, st0 and cyl are all zero and every present cylinder is zero.
- R2: A seek step drives dir to 1 when the destination is above the present cylinder and to 0 when it is below. A recalibrate step drives dir to 0. dir holds its value between steps.
- R3: A step is a single-clock pulse that follows a millisecond tick. Successive steps of one command are cmd_srt ticks apart, and a cmd_srt value of 0 gives 16 ticks.
- R4: A seek issues exactly |destination − present| steps. Each step moves the present cylinder by one toward the destination. The command completes on the first step-rate evaluation tick after the destination is reached.
- R5: From the cycle after an accepted start until completion, busy has exactly the active drive's bit set (bit i for drive i). At all other times busy is zero.
- R6: On successful completion, irq rises and busy clears. The latched status is bit 5 = 1 (seek end), bits 7:6 = 00, bit 4 = 0, bits 3:2 = 0, and bits 1:0 = drive number.
- R7: A seek whose destination equals the present cylinder completes in the cycle after the start. It issues no step and never sets busy.
- R8: A sense request while irq is high loads st0 with the latched status and cyl with the present cylinder of the drive that completed, and it clears irq. A sense request while irq is low loads st0 with 0x80 and leaves cyl unchanged.
- R9: A recalibrate steps outward once per evaluation tick until track0 is seen high at an evaluation tick. It then completes successfully and sets that drive's present cylinder to 0.
- R10: If track0 is still low at the evaluation after 77 recalibrate steps, the command ends with status bits 7:6 = 01, bit 5 = 1 and bit 4 = 1 (status 0x70 | drive). That drive's present cylinder is left unchanged.
- R11: A start request while a command is running is ignored and changes no present cylinder.
- R12: Each drive keeps its own present cylinder. A command on one drive does not alter another drive's cylinder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | Single-cycle pulse once per millisecond |
| cmd_start | input | 1 | Start request, one cycle |
| cmd_recal | input | 1 | 1 = recalibrate, 0 = seek |
| cmd_drive | input | DRV_W | Drive number for the command |
| cmd_dest | input | 8 | Destination cylinder for a seek |
| cmd_srt | input | SRT_W | Step spacing in millisecond ticks (0 = 16) |
| track0 | input | 1 | Track-0 sense of the selected drive |
| sense_req | input | 1 | Sense request, one cycle |
| step | output | 1 | Step pulse to the drive |
| dir | output | 1 | Step direction, 1 = inward |
| busy | output | N_DRIVES | Per-drive positioning-in-progress bits |
| irq | output | 1 | Completion interrupt |
| st0 | output | 8 | Status byte returned by the last sense |
| cyl | output | 8 | Cylinder returned by the last sense |

## Verification
Several properties are checked on every cycle: a step always follows an evaluation tick, at most one busy bit is set, a step occurs only while busy is set, the timer remainder stays below the programmed spacing, the recalibrate counter stays within its limit, irq rises only on a completion, and a sense clears a pending irq. Other behaviour only shows up over whole scenarios. This includes the exact step counts and the tick spacing, the direction choice, immediate completion, the failure status after the step limit, ignored starts, and per-drive cylinder independence. The bench drives those scenarios against its own behavioural model and compares every output on every cycle.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef logic [7:0] cyl_t;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_RUN  = 1'b1
  } hs_state_e;

  // step spacing in ticks; a zero code selects the longest spacing
  function automatic int step_period(input int srt_code, input int srt_w);
    return (srt_code == 0) ? (1 << srt_w) : srt_code;
  endfunction

  // 1 = inward (toward higher cylinders)
  function automatic logic seek_dir(input cyl_t present, input cyl_t target);
    return target > present;
  endfunction

  function automatic logic [7:0] build_st0(input logic fail, input logic [1:0] unit);
    return {(fail ? 2'b01 : 2'b00), 1'b1, fail, 2'b00, unit};
  endfunction

endpackage

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int PER_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             run,
  input  logic             ms_tick,
  input  logic [PER_W-1:0] period,
  output logic             eval
);

  logic [PER_W-1:0] rem_q;

  assign eval = run && ms_tick && (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rem_q <= '0;
    else if (arm)             rem_q <= '0;
    else if (run && ms_tick)  rem_q <= eval ? (period - 1'b1) : (rem_q - 1'b1);
  end

  AST_REM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem_q < period)); // R3

endmodule

// File: rtl/hs_cyl_bank.sv
module hs_cyl_bank
  import hs_pkg::*;
#(
  parameter int N_DRIVES = 2,
  parameter int DRV_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DRV_W-1:0] wr_sel,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  input  logic [DRV_W-1:0] rd_a_sel,
  input  logic [DRV_W-1:0] rd_b_sel,
  output cyl_t             rd_a,
  output cyl_t             rd_b
);

  cyl_t pcn_q [N_DRIVES];

  for (genvar g = 0; g < N_DRIVES; g++) begin : g_drv
    cyl_t r_q;
    logic hit;
    assign hit = (wr_sel == DRV_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           r_q <= '0;
      else if (hit && clr)  r_q <= '0;
      else if (hit && inc)  r_q <= r_q + 1'b1;
      else if (hit && dec)  r_q <= r_q - 1'b1;
    end
    assign pcn_q[g] = r_q;
  end

  always_comb begin
    rd_a = '0;
    rd_b = '0;
    for (int i = 0; i < N_DRIVES; i++) begin
      if (rd_a_sel == DRV_W'(i)) rd_a = pcn_q[i];
      if (rd_b_sel == DRV_W'(i)) rd_b = pcn_q[i];
    end
  end

  AST_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec)); // R4

endmodule

// File: rtl/hs_seq.sv
module hs_seq
  import hs_pkg::*;
#(
  parameter int N_DRIVES  = 2,
  parameter int DRV_W     = 1,
  parameter int SRT_W     = 4,
  parameter int RECAL_MAX = 77,
  localparam int PER_W    = SRT_W + 1,
  localparam int NST_W    = $clog2(RECAL_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_start,
  input  logic                cmd_recal,
  input  logic [DRV_W-1:0]    cmd_drive,
  input  cyl_t                cmd_dest,
  input  logic [SRT_W-1:0]    cmd_srt,
  input  logic                track0,
  input  logic                eval,
  input  cyl_t                cur_pcn,
  output logic                arm,
  output logic                run,
  output logic [PER_W-1:0]    period,
  output logic [DRV_W-1:0]    bank_sel,
  output logic                pcn_inc,
  output logic                pcn_dec,
  output logic                pcn_clr,
  output logic                done_evt,
  output logic                done_fail,
  output logic [DRV_W-1:0]    done_drv,
  output logic                step,
  output logic                dir,
  output logic [N_DRIVES-1:0] busy
);

  hs_state_e        state_q;
  logic [DRV_W-1:0] drv_q;
  cyl_t             dest_q;
  logic             recal_q;
  logic [PER_W-1:0] per_q;
  logic [NST_W-1:0] nst_q;
  logic             step_q, dir_q;

  // named internal events
  logic start_go, imm_done, finish, fail, do_step, step_dir;

  always_comb begin
    start_go = 1'b0;
    imm_done = 1'b0;
    finish   = 1'b0;
    fail     = 1'b0;
    do_step  = 1'b0;
    step_dir = 1'b0;
    pcn_inc  = 1'b0;
    pcn_dec  = 1'b0;
    pcn_clr  = 1'b0;
    if (state_q == HS_IDLE) begin
      if (cmd_start) begin
        if (!cmd_recal && (cmd_dest == cur_pcn)) imm_done = 1'b1;
        else                                     start_go = 1'b1;
      end
    end else if (eval) begin
      if (!recal_q) begin
        if (cur_pcn == dest_q) begin
          finish = 1'b1;
        end else begin
          do_step  = 1'b1;
          step_dir = seek_dir(cur_pcn, dest_q);
          pcn_inc  = step_dir;
          pcn_dec  = !step_dir;
        end
      end else if (track0) begin
        finish  = 1'b1;
        pcn_clr = 1'b1;
      end else if (nst_q == NST_W'(RECAL_MAX)) begin
        finish = 1'b1;
        fail   = 1'b1;
      end else begin
        do_step = 1'b1;
      end
    end
  end

  assign run       = (state_q == HS_RUN);
  assign arm       = start_go;
  assign period    = per_q;
  assign bank_sel  = run ? drv_q : cmd_drive;
  assign done_evt  = imm_done || finish;
  assign done_fail = fail;
  assign done_drv  = imm_done ? cmd_drive : drv_q;
  assign step      = step_q;
  assign dir       = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      drv_q   <= '0;
      dest_q  <= '0;
      recal_q <= 1'b0;
      per_q   <= PER_W'(1);
      nst_q   <= '0;
      step_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      step_q <= do_step;
      if (do_step) dir_q <= step_dir;
      if (start_go) begin
        state_q <= HS_RUN;
        drv_q   <= cmd_drive;
        dest_q  <= cmd_dest;
        recal_q <= cmd_recal;
        per_q   <= PER_W'(step_period(int'(cmd_srt), SRT_W));
        nst_q   <= '0;
      end else if (finish) begin
        state_q <= HS_IDLE;
      end else if (do_step && recal_q) begin
        nst_q <= nst_q + 1'b1;
      end
    end
  end

  always_comb begin
    busy = '0;
    for (int i = 0; i < N_DRIVES; i++)
      busy[i] = run && (drv_q == DRV_W'(i));
  end

  AST_STEP_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $past(eval)); // R3

  AST_BUSY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy)); // R5

  AST_STEP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (busy != '0)); // R5

  AST_RECAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    nst_q <= NST_W'(RECAL_MAX)); // R10

endmodule

// File: rtl/hs_report.sv
module hs_report
  import hs_pkg::*;
#(
  parameter int DRV_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  logic             done_fail,
  input  logic [DRV_W-1:0] done_drv,
  input  logic             sense_req,
  input  cyl_t             rd_pcn,
  output logic [DRV_W-1:0] lat_drv,
  output logic             irq,
  output logic [7:0]       st0_o,
  output cyl_t             cyl_o
);

  logic [7:0] lat_st0_q;
  logic       sense_hit;

  assign sense_hit = sense_req && irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_st0_q <= '0;
      lat_drv   <= '0;
      irq       <= 1'b0;
      st0_o     <= '0;
      cyl_o     <= '0;
    end else begin
      if (sense_hit) begin
        st0_o <= lat_st0_q;
        cyl_o <= rd_pcn;
      end else if (sense_req) begin
        st0_o <= 8'h80;
      end
      if (done_evt) begin
        lat_st0_q <= build_st0(done_fail, 2'(done_drv));
        lat_drv   <= done_drv;
        irq       <= 1'b1;
      end else if (sense_hit) begin
        irq <= 1'b0;
      end
    end
  end

  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_evt)); // R6

  AST_SENSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_req && irq && !done_evt) |=> !irq); // R8

endmodule

// File: rtl/head_step_ctrl.sv
module head_step_ctrl
  import hs_pkg::*;
#(
  parameter int N_DRIVES  = 2,
  parameter int SRT_W     = 4,
  parameter int RECAL_MAX = 77,
  localparam int DRV_W    = (N_DRIVES > 1) ? $clog2(N_DRIVES) : 1,
  localparam int PER_W    = SRT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ms_tick,
  input  logic                cmd_start,
  input  logic                cmd_recal,
  input  logic [DRV_W-1:0]    cmd_drive,
  input  logic [7:0]          cmd_dest,
  input  logic [SRT_W-1:0]    cmd_srt,
  input  logic                track0,
  input  logic                sense_req,
  output logic                step,
  output logic                dir,
  output logic [N_DRIVES-1:0] busy,
  output logic                irq,
  output logic [7:0]          st0,
  output logic [7:0]          cyl
);

  logic             arm, run, eval;
  logic [PER_W-1:0] period;
  logic [DRV_W-1:0] bank_sel, done_drv, lat_drv;
  logic             pcn_inc, pcn_dec, pcn_clr;
  logic             done_evt, done_fail;
  cyl_t             cur_pcn, rep_pcn;

  hs_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .run(run),
    .ms_tick(ms_tick), .period(period), .eval(eval)
  );

  hs_cyl_bank #(.N_DRIVES(N_DRIVES), .DRV_W(DRV_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_sel(bank_sel),
    .inc(pcn_inc), .dec(pcn_dec), .clr(pcn_clr),
    .rd_a_sel(bank_sel), .rd_b_sel(lat_drv),
    .rd_a(cur_pcn), .rd_b(rep_pcn)
  );

  hs_seq #(.N_DRIVES(N_DRIVES), .DRV_W(DRV_W), .SRT_W(SRT_W),
           .RECAL_MAX(RECAL_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_recal(cmd_recal),
    .cmd_drive(cmd_drive), .cmd_dest(cmd_dest), .cmd_srt(cmd_srt),
    .track0(track0), .eval(eval), .cur_pcn(cur_pcn),
    .arm(arm), .run(run), .period(period), .bank_sel(bank_sel),
    .pcn_inc(pcn_inc), .pcn_dec(pcn_dec), .pcn_clr(pcn_clr),
    .done_evt(done_evt), .done_fail(done_fail), .done_drv(done_drv),
    .step(step), .dir(dir), .busy(busy)
  );

  hs_report #(.DRV_W(DRV_W)) u_report (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .done_fail(done_fail),
    .done_drv(done_drv), .sense_req(sense_req), .rd_pcn(rep_pcn),
    .lat_drv(lat_drv), .irq(irq), .st0_o(st0), .cyl_o(cyl)
  );

endmodule

// File: tb/head_step_ctrl_bench.sv
module head_step_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       cmd_start = 1'b0;
  logic       cmd_recal = 1'b0;
  logic [0:0] cmd_drive = '0;
  logic [7:0] cmd_dest = '0;
  logic [3:0] cmd_srt = '0;
  logic       track0 = 1'b0;
  logic       sense_req = 1'b0;
  logic       step, dir, irq;
  logic [1:0] busy;
  logic [7:0] st0, cyl;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  head_step_ctrl u_head_step_ctrl (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cmd_start(cmd_start),
    .cmd_recal(cmd_recal), .cmd_drive(cmd_drive), .cmd_dest(cmd_dest),
    .cmd_srt(cmd_srt), .track0(track0), .sense_req(sense_req),
    .step(step), .dir(dir), .busy(busy), .irq(irq), .st0(st0), .cyl(cyl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  m_pcn [4];
  bit  m_run, m_recal, m_irq, m_step, m_dir;
  int  m_drv, m_dest, m_per, m_rem, m_nst, m_lat_drv, m_lat_st0, m_st0o, m_cylo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pcn[i]) m_pcn[i] = 0;
      m_run = 0; m_recal = 0; m_irq = 0; m_step = 0; m_dir = 0;
      m_drv = 0; m_dest = 0; m_per = 1; m_rem = 0; m_nst = 0;
      m_lat_drv = 0; m_lat_st0 = 0; m_st0o = 0; m_cylo = 0;
    end else begin
      bit clr_irq, done, fail;
      int ddrv;
      clr_irq = 0; done = 0; fail = 0; ddrv = 0;
      if (sense_req) begin
        if (m_irq) begin
          m_st0o = m_lat_st0; m_cylo = m_pcn[m_lat_drv]; clr_irq = 1;
        end else m_st0o = 'h80;
      end
      m_step = 0;
      if (!m_run) begin
        if (cmd_start) begin
          if (!cmd_recal && int'(cmd_dest) == m_pcn[cmd_drive]) begin
            done = 1; ddrv = int'(cmd_drive);
          end else begin
            m_run = 1; m_drv = int'(cmd_drive); m_dest = int'(cmd_dest);
            m_recal = cmd_recal; m_per = (cmd_srt == 0) ? 16 : int'(cmd_srt);
            m_rem = 0; m_nst = 0;
          end
        end
      end else if (ms_tick) begin
        if (m_rem > 0) m_rem--;
        else begin
          m_rem = m_per - 1;
          if (!m_recal) begin
            if (m_pcn[m_drv] == m_dest) begin
              done = 1; ddrv = m_drv; m_run = 0;
            end else begin
              m_step = 1;
              if (m_dest > m_pcn[m_drv]) begin m_dir = 1; m_pcn[m_drv]++; end
              else begin m_dir = 0; m_pcn[m_drv]--; end
            end
          end else if (track0) begin
            done = 1; ddrv = m_drv; m_pcn[m_drv] = 0; m_run = 0;
          end else if (m_nst == 77) begin
            done = 1; fail = 1; ddrv = m_drv; m_run = 0;
          end else begin
            m_step = 1; m_dir = 0; m_nst++;
          end
        end
      end
      if (done) begin
        m_irq = 1; m_lat_drv = ddrv;
        m_lat_st0 = (fail ? 'h50 : 'h00) | 'h20 | ddrv;
      end else if (clr_irq) m_irq = 0;
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  int  tk = 0;
  int  n_steps = 0, last_tk = -1, spacing = -1;
  bit  spacing_bad = 0, busy_seen = 0;
  int  t0_after = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(step == m_step, "R3 step", step, m_step);
      chk(dir == m_dir, "R2 dir", dir, m_dir);
      chk(int'(busy) == (m_run ? (1 << m_drv) : 0), "R5 busy", busy, m_run ? (1 << m_drv) : 0);
      chk(irq == m_irq, "R6 irq", irq, m_irq);
      chk(int'(st0) == m_st0o, "R8 st0", st0, m_st0o);
      chk(int'(cyl) == m_cylo, "R8 cyl", cyl, m_cylo);
      if (busy != 0) busy_seen = 1;
      if (step) begin
        n_steps++;
        if (last_tk >= 0) begin
          if (spacing < 0) spacing = tk - last_tk;
          else if (tk - last_tk != spacing) spacing_bad = 1;
        end
        last_tk = tk;
      end
    end
  end

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      ms_tick = 1'b1; tk++;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    track0 = (t0_after >= 0) && (n_steps >= t0_after);
  end

  task automatic pulse_start(input bit rc, input int drv, input int dst, input int srt);
    @(negedge clk);
    cmd_start = 1'b1; cmd_recal = rc; cmd_drive = 1'(drv);
    cmd_dest = 8'(dst); cmd_srt = 4'(srt);
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic do_cmd(input bit rc, input int drv, input int dst, input int srt);
    n_steps = 0; last_tk = -1; spacing = -1; spacing_bad = 0; busy_seen = 0;
    pulse_start(rc, drv, dst, srt);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq == 1'b1, req, irq, 1);
  endtask

  task automatic sense();
    @(negedge clk); sense_req = 1'b1;
    @(negedge clk); sense_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(step == 0 && busy == 0 && irq == 0, "R1 outputs idle", {step, busy, irq}, 0);
    chk(st0 == 0 && cyl == 0, "R1 status zero", {st0, cyl}, 0);
    sense();
    chk(st0 == 8'h80, "R8 no pending st0", st0, 'h80);
    chk(cyl == 0, "R1 cylinder zero", cyl, 0);

    // inward seek drive 0 to 3, spacing 2
    do_cmd(0, 0, 3, 2);
    wait_irq("R6 seek done");
    chk(n_steps == 3, "R4 inward step count", n_steps, 3);
    chk(spacing == 2 && !spacing_bad, "R3 spacing srt=2", spacing, 2);
    chk(dir == 1, "R2 inward dir", dir, 1);
    chk(busy == 0, "R6 busy cleared", busy, 0);
    sense();
    chk(st0 == 8'h20, "R6 status ok drive0", st0, 'h20);
    chk(cyl == 3, "R8 cylinder reported", cyl, 3);
    chk(irq == 0, "R8 irq cleared", irq, 0);
    sense();
    chk(st0 == 8'h80 && cyl == 3, "R8 second sense", st0, 'h80);

    // outward seek drive 0 to 1
    do_cmd(0, 0, 1, 1);
    wait_irq("R6 seek down done");
    chk(n_steps == 2, "R4 outward step count", n_steps, 2);
    chk(dir == 0, "R2 outward dir", dir, 0);
    chk(spacing == 1 && !spacing_bad, "R3 spacing srt=1", spacing, 1);
    sense();
    chk(cyl == 1, "R4 cylinder after outward", cyl, 1);

    // drive 1 seek with srt=0, and an ignored start
    do_cmd(0, 1, 5, 0);
    chk(busy == 2'b10, "R5 busy drive1", busy, 2);
    repeat (10) @(negedge clk);
    pulse_start(0, 0, 9, 1);
    wait_irq("R6 drive1 done");
    chk(n_steps == 5, "R4 drive1 steps", n_steps, 5);
    chk(spacing == 16 && !spacing_bad, "R3 spacing srt=0", spacing, 16);
    sense();
    chk(st0 == 8'h21 && cyl == 5, "R6 status drive1", st0, 'h21);

    // equal destination on drive 0 proves R11 and R12
    do_cmd(0, 0, 1, 3);
    chk(irq == 1, "R7 immediate completion", irq, 1);
    chk(n_steps == 0 && !busy_seen, "R7 no step no busy", n_steps, 0);
    sense();
    chk(st0 == 8'h20, "R7 immediate status", st0, 'h20);
    chk(cyl == 1, "R11 R12 drive0 cylinder kept", cyl, 1);

    // recalibrate drive 1, track 0 after 3 steps
    t0_after = 3;
    do_cmd(1, 1, 0, 1);
    wait_irq("R9 recal done");
    t0_after = -1;
    chk(n_steps == 3, "R9 recal steps", n_steps, 3);
    chk(dir == 0, "R2 recal dir", dir, 0);
    sense();
    chk(st0 == 8'h21 && cyl == 0, "R9 recal status and cylinder", cyl, 0);

    // recalibrate drive 0 with no track 0
    do_cmd(1, 0, 0, 1);
    wait_irq("R10 recal fail done");
    chk(n_steps == 77, "R10 step limit", n_steps, 77);
    sense();
    chk(st0 == 8'h70, "R10 failure status", st0, 'h70);
    chk(cyl == 1, "R10 cylinder unchanged", cyl, 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule